// File: doc/BRIEF.md
# Two-LUT logic tile with carry chain

This block is one tile of a small reconfigurable fabric that sits next to a processor. The tile holds two lookup tables, A and B. Each table reads a 3-bit index and returns a 2-bit result, so one table can compute both the sum and the carry of a full-adder bit. Carry and cascade paths run directly from one tile to the next and from table A into table B, without going through general routing.

The truth tables and three mode bits sit in one serial configuration store. While `config_en` is high, that store shifts one bit per clock, and its far end appears on `cfg_so`. Tiles can be daisy-chained into one long configuration path, and the same path reads the stored bits back. When `config_en` is low, the store holds its contents and the tile is purely combinational.

A typical use chains N tiles carry-out to carry-in and configures every table as a full adder. The result is a 2N-bit ripple adder.

Top module: `clb_tile`

## Requirements
- R1: Each rising clock edge with `config_en` high shifts the 35-bit store right by one and loads `cfg_si` into bit 34. Bits are therefore sent LSB first, and the first bit sent ends in bit 0. Store layout:
  - bits 15..0: table A
  - bits 31..16: table B
  - bit 32: A carry mode
  - bit 33: B carry mode
  - bit 34: cascade
- R2: `cfg_so` always shows store bit 0. Shifting out the whole store returns the bits in the order they were loaded. Feeding `cfg_so` back into `cfg_si` during such a readback leaves the configuration unchanged.
- R3: While `config_en` is high, `a_out`, `b_out` and `carry_out` are all 0, whatever the other inputs are.
- R4: While `config_en` is low, the store does not change, whatever `cfg_si` carries. The outputs are then a pure combinational function of the inputs and the store.
- R5: A table with index i = {in2,in1,in0} drives out[0] from its table bit 2i and out[1] from its table bit 2i+1.
- R6: With A carry mode set, index bit in2 of table A is taken from `carry_in` and `a_in[2]` is ignored.
- R7: With B carry mode set, index bit in2 of table B is taken from table A's out[1] and `b_in[2]` is ignored.
- R8: With cascade set, index bit in0 of table B is taken from table A's out[0] and `b_in[0]` is ignored. R7 and R8 may be active together.
- R9: Outside configuration, `carry_out` equals table B's out[1].
- R10: Reset clears the store to all zeros, so all outputs and `cfg_so` are 0.
- R11: Tiles chained through the carry and configuration paths, with both tables set as full adders, produce the exact binary sum of their operands plus the incoming carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Active-low reset, clears the store |
| config_en | input | 1 | Shift enable; forces outputs to zero |
| cfg_si | input | 1 | Serial configuration in |
| cfg_so | output | 1 | Serial configuration out / readback |
| a_in | input | 3 | Routed inputs of table A |
| b_in | input | 3 | Routed inputs of table B |
| carry_in | input | 1 | Carry from the previous tile |
| a_out | output | 2 | Table A result |
| b_out | output | 2 | Table B result |
| carry_out | output | 1 | Carry to the next tile |

## Verification
Two paths can both act on table B's index in the same evaluation: the carry path from table A and the cascade path from table A's out[0]. The bench therefore loads random configurations with both mode bits set, plus one directed tile with both set. It compares every output against a bench-side model that applies both substitutions to the index.

Configuration shifting and evaluation also overlap, because the data inputs keep toggling while the store shifts. During these periods the outputs are judged against all-zero values. After each load, they are judged against the model.

// File: rtl/clb_tile.sv
module clb_tile #(
  parameter int LUT_K    = 3,
  parameter int LUT_OUTS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                config_en,
  input  logic                cfg_si,
  output logic                cfg_so,
  input  logic [LUT_K-1:0]    a_in,
  input  logic [LUT_K-1:0]    b_in,
  input  logic                carry_in,
  output logic [LUT_OUTS-1:0] a_out,
  output logic [LUT_OUTS-1:0] b_out,
  output logic                carry_out
);
  localparam int LUT_BITS  = LUT_OUTS << LUT_K;
  localparam int MODE_BITS = 3;
  localparam int CFG_W     = 2 * LUT_BITS + MODE_BITS;
  localparam int A_CY      = 2 * LUT_BITS;
  localparam int B_CY      = A_CY + 1;
  localparam int CASC      = A_CY + 2;

  logic [CFG_W-1:0]    cfg;
  logic [LUT_BITS-1:0] tab_a, tab_b;
  logic [LUT_K-1:0]    idx_a, idx_b;
  logic [LUT_OUTS-1:0] res_a, res_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cfg <= '0;
    else if (config_en) cfg <= {cfg_si, cfg[CFG_W-1:1]};

  assign cfg_so = cfg[0];
  assign tab_a  = cfg[LUT_BITS-1:0];
  assign tab_b  = cfg[2*LUT_BITS-1:LUT_BITS];

  always_comb begin
    idx_a = a_in;
    if (cfg[A_CY]) idx_a[LUT_K-1] = carry_in;
    res_a = tab_a[int'(idx_a)*LUT_OUTS +: LUT_OUTS];
    idx_b = b_in;
    if (cfg[B_CY]) idx_b[LUT_K-1] = res_a[1];
    if (cfg[CASC]) idx_b[0]       = res_a[0];
    res_b = tab_b[int'(idx_b)*LUT_OUTS +: LUT_OUTS];
  end

  assign a_out     = config_en ? '0 : res_a;
  assign b_out     = config_en ? '0 : res_b;
  assign carry_out = !config_en && res_b[1];
endmodule

// File: rtl/clb_tile_chk.sv
module clb_tile_chk #(
  parameter int LUT_K    = 3,
  parameter int LUT_OUTS = 2,
  parameter int CFG_W    = 35
) (
  input logic                clk,
  input logic                rst_n,
  input logic                config_en,
  input logic                cfg_si,
  input logic                cfg_so,
  input logic [LUT_K-1:0]    a_in,
  input logic [LUT_K-1:0]    b_in,
  input logic                carry_in,
  input logic [LUT_OUTS-1:0] a_out,
  input logic [LUT_OUTS-1:0] b_out,
  input logic                carry_out,
  input logic [CFG_W-1:0]    cfg
);
  // R3
  quiet_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    config_en |-> (a_out == '0 && b_out == '0 && !carry_out));

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    config_en |=> cfg[CFG_W-1] == $past(cfg_si));

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    config_en |=> cfg_so == $past(cfg[1]));

  // R4
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !config_en |=> $stable(cfg));

  // R4
  comb_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!config_en && !$past(config_en) && $stable(a_in) && $stable(b_in) && $stable(carry_in))
      |-> ($stable(a_out) && $stable(b_out) && $stable(carry_out)));
endmodule

bind clb_tile clb_tile_chk #(.LUT_K(LUT_K), .LUT_OUTS(LUT_OUTS), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .config_en(config_en), .cfg_si(cfg_si), .cfg_so(cfg_so),
  .a_in(a_in), .b_in(b_in), .carry_in(carry_in), .a_out(a_out), .b_out(b_out),
  .carry_out(carry_out), .cfg(cfg));

// File: tb/clb_tile_tb.sv
module clb_tile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 3;
  localparam int CW = 35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic config_en = 1'b0;
  logic si = 1'b0;
  logic cin = 1'b0;
  logic [2:0] a_in [NT];
  logic [2:0] b_in [NT];
  logic [1:0] a_out [NT];
  logic [1:0] b_out [NT];
  logic so [NT];
  logic cout [NT];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clb_tile u_dut (.clk(clk), .rst_n(rst_n), .config_en(config_en), .cfg_si(si), .cfg_so(so[0]),
    .a_in(a_in[0]), .b_in(b_in[0]), .carry_in(cin), .a_out(a_out[0]), .b_out(b_out[0]),
    .carry_out(cout[0]));

  for (genvar t = 1; t < NT; t++) begin : g_tile
    clb_tile u_tile (.clk(clk), .rst_n(rst_n), .config_en(config_en), .cfg_si(so[t-1]), .cfg_so(so[t]),
      .a_in(a_in[t]), .b_in(b_in[t]), .carry_in(cout[t-1]), .a_out(a_out[t]), .b_out(b_out[t]),
      .carry_out(cout[t]));
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fa_table();
    logic [15:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [2:0] v;
      v = 3'(i);
      r[2*i]   = ^v;
      r[2*i+1] = (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    end
    return r;
  endfunction

  // returns {carry_out, b_out, a_out}
  function automatic logic [4:0] tile_ref(logic [CW-1:0] c, logic [2:0] a, logic [2:0] b, logic ci);
    logic [2:0] ia, ib;
    logic [1:0] ra, rb;
    ia = a;
    if (c[32]) ia[2] = ci;
    ra = c[{ia, 1'b0} +: 2];
    ib = b;
    if (c[33]) ib[2] = ra[1];
    if (c[34]) ib[0] = ra[0];
    rb = c[16 + {ib, 1'b0} +: 2];
    return {rb[1], rb, ra};
  endfunction

  logic [CW-1:0] cfgs [NT];

  // R1 load order: last tile first, each tile LSB first
  task automatic load_all();
    for (int t = NT-1; t >= 0; t--)
      for (int i = 0; i < CW; i++) begin
        @(negedge clk);
        config_en = 1'b1;
        si = cfgs[t][i];
        a_in[0] = 3'($urandom); b_in[0] = 3'($urandom); cin = 1'($urandom);
        if (i == 7 && t == 0) begin
          #1;
          for (int k = 0; k < NT; k++)
            chk("R3 quiet during config", {a_out[k], b_out[k], cout[k]}, 0);
        end
      end
    @(negedge clk);
    config_en = 1'b0;
    si = 1'b0;
  endtask

  task automatic check_model(string req);
    logic c;
    logic [4:0] e;
    c = cin;
    #1;
    for (int t = 0; t < NT; t++) begin
      e = tile_ref(cfgs[t], a_in[t], b_in[t], c);
      chk(req, {27'd0, cout[t], b_out[t], a_out[t]}, {27'd0, e});
      c = e[4];
    end
  endtask

  task automatic rand_inputs();
    for (int t = 0; t < NT; t++) begin
      a_in[t] = 3'($urandom);
      b_in[t] = 3'($urandom);
    end
    cin = 1'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [15:0] fa;
    logic [7:0] x, y;
    logic ci;
    logic [7:0] sum;
    seed = $urandom(32'hC1B5);
    for (int t = 0; t < NT; t++) begin a_in[t] = 3'b101; b_in[t] = 3'b011; end
    cin = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    for (int t = 0; t < NT; t++)
      chk("R10 reset outputs", {so[t], a_out[t], b_out[t], cout[t]}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset release", {31'd0, so[NT-1]}, 0);

    // R11 full-adder ripple chain, exhaustive over operands and carry in
    fa = fa_table();
    for (int t = 0; t < NT; t++) cfgs[t] = {3'b011, fa, fa};
    load_all();
    for (int v = 0; v < (1 << (4*NT+1)); v++) begin
      x = 8'(v & ((1 << 2*NT) - 1));
      y = 8'((v >> 2*NT) & ((1 << 2*NT) - 1));
      ci = 1'(v >> 4*NT);
      cin = ci;
      for (int t = 0; t < NT; t++) begin
        a_in[t] = {1'($urandom), y[2*t], x[2*t]};
        b_in[t] = {1'($urandom), y[2*t+1], x[2*t+1]};
      end
      #1;
      sum = '0;
      for (int t = 0; t < NT; t++) begin
        sum[2*t]   = a_out[t][0];
        sum[2*t+1] = b_out[t][0];
      end
      sum[2*NT] = cout[NT-1];
      // R6 R7 R9 exercised by ignored in2 bits and the carry output
      chk("R11 adder sum", {24'd0, sum}, {24'd0, x + y + 8'(ci)});
      #1;
    end

    // R2 readback with recirculation
    for (int t = NT-1; t >= 0; t--)
      for (int i = 0; i < CW; i++) begin
        @(negedge clk);
        config_en = 1'b1;
        si = so[NT-1];
        chk("R2 readback bit", {31'd0, so[NT-1]}, {31'd0, cfgs[t][i]});
      end
    @(negedge clk);
    config_en = 1'b0;
    rand_inputs();
    check_model("R2 config kept after readback");

    // R5 R8 directed: cascade and carry into B together, plain table A
    cfgs[0] = {3'b110, 16'h9C3A, 16'hE41B};
    cfgs[1] = {3'b100, 16'h5AF0, 16'h0FF1};
    cfgs[2] = {3'b000, 16'h1234, 16'h8765};
    load_all();
    for (int v = 0; v < 64; v++) begin
      rand_inputs();
      check_model("R5 R8 directed modes");
    end

    // R1 R5 R6 R7 R8 R9 random configurations
    for (int r = 0; r < 25; r++) begin
      for (int t = 0; t < NT; t++) cfgs[t] = {3'($urandom), 32'($urandom)};
      if (r % 4 == 0) cfgs[0][34:32] = 3'b111;
      load_all();
      for (int v = 0; v < 24; v++) begin
        rand_inputs();
        check_model("R1 R5 R6 R7 R8 R9 random config");
      end
      // R4 store holds with config_en low and noise on cfg_si
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        si = 1'($urandom);
      end
      rand_inputs();
      check_model("R4 hold without enable");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule